// File: doc/BRIEF.md
# Protected System Reset Controller

This block is the register-mapped reset manager of a chip. It gathers reset requests from the power-on detector, the external reset pin, the watchdog, the brown-out detector, the core's system-reset request and the debugger. It also accepts software commands over a simple synchronous register bus. From these it drives a chip-wide reset, a core-domain reset, a DMA reset and a vector of per-peripheral resets. It records the cause of each reset in sticky flags that survive the reset itself. A flag clears only when software writes 1 to it.

Some fields are protected. These are the chip and core one-shot triggers, the DMA reset and the power-on disable code. They accept writes only while the lock input reports the unlocked state. The chip and core triggers drive a small pulse sequencer with three states. In IDLE, an accepted trigger moves it to CHIP or to CPU. CHIP and CPU each hold for `PULSE_LEN` cycles and then return to IDLE. A trigger is accepted only in IDLE, and the chip trigger wins when both are written together. The power-on request is ignored while the 16-bit code field holds 0x5AA5. Most other reset sources wipe that field back to zero.

Register words, selected by `reg_addr`: 0 reset-cause flags, 1 one-shot/DMA control, 2 peripheral resets, 3 power-on disable code (bits 15:0), 4 lock status (bit 0). Reads are combinational.

Top module: `sysrst_top`

## Requirements
- R1: After `rst_n` is released, every register word reads 0 and `chip_rst_o`, `cpu_rst_o`, `dma_rst_o` and `periph_rst_o` are low.
- R2: Word 4 bit 0 reads the `unlock_i` input (1 = unlocked). While `unlock_i` is 0, writes to word 1 bits 0..2 and to word 3 are dropped.
- R3: An unlocked write of 1 to word 1 bit 0 moves the sequencer from IDLE to CHIP on the next edge. For `PULSE_LEN` (default 2) cycles, `chip_rst_o` and `cpu_rst_o` are high and word 1 bit 0 reads 1. After that the bit reads 0. The write also sets cause bit 0.
- R4: An unlocked write of 1 to word 1 bit 1, with bit 0 clear, moves the sequencer to CPU. For `PULSE_LEN` cycles, `cpu_rst_o` is high and `chip_rst_o` stays low. The write sets cause bit 7. A write with both bits set takes the CHIP path only.
- R5: Word 1 bit 2 is a level DMA reset. `dma_rst_o` follows it until software writes it back to 0. Writing 0 to word 1 bits 0 or 1 starts no pulse.
- R6: Cause flags are word 0 bits 0 (power-on or chip one-shot), 1 (pin), 2 (watchdog), 4 (brown-out), 5 (core request) and 7 (CPU one-shot). Each is set while its source is active. A flag is cleared only by writing 1 to it, and a set in the same cycle wins over the clear. Writing 0 has no effect, and the other bits read 0.
- R7: `req_por` causes a chip reset and sets cause bit 0 only while word 3 differs from 0x5AA5.
- R8: Word 3 returns to 0 on an effective power-on request, `req_pin`, `req_wdt`, `req_bod`, `req_dbg` or a CHIP pulse. `req_sys` leaves it unchanged.
- R9: Word 2 holds the peripheral resets at bits 1-5, 8, 9, 12, 13, 16, 17, 20, 22, 26, 28, 30 and 31. `periph_rst_o` mirrors the word. Other bits read 0. Word 2 is not protected.
- R10: Any chip-level reset clears the DMA bit and word 2. This includes every hardware source, an effective power-on request and the CHIP pulse. The cause flags are not cleared.
- R11: `chip_rst_o` is high in the same cycle as `req_pin`, `req_wdt`, `req_bod`, `req_sys`, `req_dbg` or an effective `req_por`. `cpu_rst_o` is high whenever `chip_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset of the controller, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| unlock_i | input | 1 | Protected-field unlock state |
| req_por | input | 1 | Power-on reset request |
| req_pin | input | 1 | External pin reset request |
| req_wdt | input | 1 | Watchdog reset request |
| req_bod | input | 1 | Brown-out reset request |
| req_sys | input | 1 | Core system-reset request |
| req_dbg | input | 1 | Debugger chip-reset request |
| chip_rst_o | output | 1 | Chip-wide reset |
| cpu_rst_o | output | 1 | Core and flash-controller reset |
| dma_rst_o | output | 1 | DMA reset |
| periph_rst_o | output | 32 | Per-peripheral resets |

## Verification
The assertions assume that the register bus presents one write per cycle, with address and data stable around the clock edge. They also assume the request inputs are synchronous levels that stay low during `rst_n`. The power-on gating property further assumes that no other request is active in the same cycle. The bench drives every input on the falling edge, so each write is a single-cycle strobe. It raises reset requests one at a time except in the set-versus-clear case. There a request is held high deliberately while its flag is written, which the assertions allow.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    localparam int REG_DW = 32;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] ADDR_CAUSE   = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_TRIG    = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_PERIPH  = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_PORCODE = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_LOCK    = 3'd4;

    localparam int CAUSE_POR = 0;
    localparam int CAUSE_PIN = 1;
    localparam int CAUSE_WDT = 2;
    localparam int CAUSE_BOD = 4;
    localparam int CAUSE_SYS = 5;
    localparam int CAUSE_CPU = 7;

    localparam int TRIG_CHIP = 0;
    localparam int TRIG_CPU  = 1;
    localparam int TRIG_DMA  = 2;

    localparam logic [REG_DW-1:0] CAUSE_MASK  = 32'h0000_00B7;
    localparam logic [REG_DW-1:0] PERIPH_MASK = 32'hD453_333E;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CHIP = 2'd1,
        ST_CPU  = 2'd2
    } pulse_st_e;

endpackage

// File: rtl/sysrst_pulse_fsm.sv
module sysrst_pulse_fsm
    import sysrst_pkg::*;
#(
    parameter int PULSE_LEN = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go_chip,
    input  logic      go_cpu,
    output pulse_st_e state,
    output logic      chip_start,
    output logic      cpu_start
);

    localparam int CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

    pulse_st_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (go_chip)     state_d = ST_CHIP;
                else if (go_cpu) state_d = ST_CPU;
            end
            ST_CHIP, ST_CPU: begin
                if (cnt_q == LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        state      = state_q;
        chip_start = (state_q == ST_IDLE) && go_chip;
        cpu_start  = (state_q == ST_IDLE) && !go_chip && go_cpu;
    end

endmodule

// File: rtl/sysrst_cause.sv
module sysrst_cause #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] q
);

    // set wins over a write-one clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= ((q & ~clr_vec) | set_vec) & MASK;
    end

endmodule

// File: rtl/sysrst_lvlreg.sv
module sysrst_lvlreg #(
    parameter int           W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // a wipe from a reset source beats a software write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (clr)   q <= '0;
        else if (wr_en) q <= wdata & MASK;
    end

endmodule

// File: rtl/sysrst_top.sv
module sysrst_top
    import sysrst_pkg::*;
#(
    parameter int                PULSE_LEN = 2,
    parameter int                CODE_W    = 16,
    parameter logic [CODE_W-1:0] POR_MAGIC = 16'h5AA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              unlock_i,
    input  logic              req_por,
    input  logic              req_pin,
    input  logic              req_wdt,
    input  logic              req_bod,
    input  logic              req_sys,
    input  logic              req_dbg,
    output logic              chip_rst_o,
    output logic              cpu_rst_o,
    output logic              dma_rst_o,
    output logic [REG_DW-1:0] periph_rst_o
);

    pulse_st_e           state;
    logic                chip_start, cpu_start;
    logic                wr_cause, wr_trig_ok, wr_periph, wr_code_ok;
    logic                por_live, hw_chip, chip_pulse, cpu_pulse;
    logic                code_wipe;
    logic [REG_DW-1:0]   cause_set, cause_q, periph_q;
    logic [CODE_W-1:0]   code_q;
    logic                dma_q;

    // bus decode
    always_comb begin
        wr_cause   = reg_wr && (reg_addr == ADDR_CAUSE);
        wr_trig_ok = reg_wr && (reg_addr == ADDR_TRIG) && unlock_i;
        wr_periph  = reg_wr && (reg_addr == ADDR_PERIPH);
        wr_code_ok = reg_wr && (reg_addr == ADDR_PORCODE) && unlock_i;
    end

    sysrst_pulse_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_chip    (wr_trig_ok && reg_wdata[TRIG_CHIP]),
        .go_cpu     (wr_trig_ok && reg_wdata[TRIG_CPU]),
        .state      (state),
        .chip_start (chip_start),
        .cpu_start  (cpu_start)
    );

    // reset source combination
    always_comb begin
        chip_pulse = (state == ST_CHIP);
        cpu_pulse  = (state == ST_CPU);
        por_live   = req_por && (code_q != POR_MAGIC);
        hw_chip    = por_live | req_pin | req_wdt | req_bod | req_sys | req_dbg;
        chip_rst_o = hw_chip | chip_pulse;
        cpu_rst_o  = chip_rst_o | cpu_pulse;
        code_wipe  = por_live | req_pin | req_wdt | req_bod | req_dbg | chip_pulse;
    end

    always_comb begin
        cause_set            = '0;
        cause_set[CAUSE_POR] = por_live | chip_start;
        cause_set[CAUSE_PIN] = req_pin;
        cause_set[CAUSE_WDT] = req_wdt;
        cause_set[CAUSE_BOD] = req_bod;
        cause_set[CAUSE_SYS] = req_sys;
        cause_set[CAUSE_CPU] = cpu_start;
    end

    sysrst_cause #(.W(REG_DW), .MASK(CAUSE_MASK)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (cause_set),
        .clr_vec (wr_cause ? reg_wdata : '0),
        .q       (cause_q)
    );

    sysrst_lvlreg #(.W(1), .MASK(1'b1)) u_dma (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_trig_ok),
        .clr   (chip_rst_o),
        .wdata (reg_wdata[TRIG_DMA]),
        .q     (dma_q)
    );

    sysrst_lvlreg #(.W(REG_DW), .MASK(PERIPH_MASK)) u_periph (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_periph),
        .clr   (chip_rst_o),
        .wdata (reg_wdata),
        .q     (periph_q)
    );

    sysrst_lvlreg #(.W(CODE_W), .MASK({CODE_W{1'b1}})) u_code (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_code_ok),
        .clr   (code_wipe),
        .wdata (reg_wdata[CODE_W-1:0]),
        .q     (code_q)
    );

    assign dma_rst_o    = dma_q;
    assign periph_rst_o = periph_q;

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CAUSE:   reg_rdata = cause_q;
            ADDR_TRIG:    begin
                reg_rdata[TRIG_CHIP] = chip_pulse;
                reg_rdata[TRIG_CPU]  = cpu_pulse;
                reg_rdata[TRIG_DMA]  = dma_q;
            end
            ADDR_PERIPH:  reg_rdata = periph_q;
            ADDR_PORCODE: reg_rdata[CODE_W-1:0] = code_q;
            ADDR_LOCK:    reg_rdata[0] = unlock_i;
            default:      reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sysrst_chk.sv
module sysrst_chk
    import sysrst_pkg::*;
#(
    parameter int                PULSE_LEN = 2,
    parameter int                CODE_W    = 16,
    parameter logic [CODE_W-1:0] POR_MAGIC = 16'h5AA5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic              unlock_i,
    input logic              req_por,
    input logic              req_pin,
    input logic              req_wdt,
    input logic              req_bod,
    input logic              req_sys,
    input logic              req_dbg,
    input logic              chip_rst_o,
    input pulse_st_e         state,
    input logic [REG_DW-1:0] cause_q,
    input logic [CODE_W-1:0] code_q,
    input logic              dma_q
);

    localparam int RW = $clog2(PULSE_LEN + 2) + 1;
    logic [RW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 run_len <= '0;
        else if (state == ST_CHIP)  run_len <= run_len + 1'b1;
        else                        run_len <= '0;
    end

    assert_locked_trigger_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_TRIG && !unlock_i && state == ST_IDLE) |=> (state == ST_IDLE));

    assert_chip_pulse_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state == ST_CHIP) |-> (run_len == RW'(PULSE_LEN)));

    assert_dma_level_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_q) |-> ($past(reg_wr && reg_addr == ADDR_TRIG) || $past(chip_rst_o)));

    assert_cause_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_CAUSE) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

    assert_magic_blocks_por_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_por && code_q == POR_MAGIC && !req_pin && !req_wdt && !req_bod && !req_sys
         && !req_dbg && state != ST_CHIP) |-> !chip_rst_o);

    assert_pin_wipes_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_pin |=> (code_q == '0));

endmodule

bind sysrst_top sysrst_chk #(
    .PULSE_LEN (PULSE_LEN),
    .CODE_W    (CODE_W),
    .POR_MAGIC (POR_MAGIC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .unlock_i   (unlock_i),
    .req_por    (req_por),
    .req_pin    (req_pin),
    .req_wdt    (req_wdt),
    .req_bod    (req_bod),
    .req_sys    (req_sys),
    .req_dbg    (req_dbg),
    .chip_rst_o (chip_rst_o),
    .state      (state),
    .cause_q    (cause_q),
    .code_q     (code_q),
    .dma_q      (dma_q)
);

// File: tb/test_sysrst_top.sv
`timescale 1ns/1ps
module test_sysrst_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        unlock_i = 1'b0;
    logic        req_por = 1'b0, req_pin = 1'b0, req_wdt = 1'b0;
    logic        req_bod = 1'b0, req_sys = 1'b0, req_dbg = 1'b0;
    logic        chip_rst_o, cpu_rst_o, dma_rst_o;
    logic [31:0] periph_rst_o;

    int checks = 0;
    int fails  = 0;

    localparam logic [2:0] A_CAUSE = 3'd0, A_TRIG = 3'd1, A_PER = 3'd2, A_CODE = 3'd3, A_LOCK = 3'd4;
    localparam logic [31:0] PMASK = 32'hD453_333E;

    always #5 clk = ~clk;

    sysrst_top i_sysrst_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .unlock_i(unlock_i),
        .req_por(req_por), .req_pin(req_pin), .req_wdt(req_wdt), .req_bod(req_bod),
        .req_sys(req_sys), .req_dbg(req_dbg), .chip_rst_o(chip_rst_o),
        .cpu_rst_o(cpu_rst_o), .dma_rst_o(dma_rst_o), .periph_rst_o(periph_rst_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_cause();
        wr(A_CAUSE, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset_state_r1();
        logic [31:0] d;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check("R1 register word after reset", d, 32'd0);
        end
        check("R1 outputs after reset", {chip_rst_o, cpu_rst_o, dma_rst_o, periph_rst_o[28:0]}, 32'd0);
    endtask

    task automatic t_lock_r2();
        logic [31:0] d;
        unlock_i = 1'b0;
        rd(A_LOCK, d);            check("R2 lock status locked", d, 32'd0);
        wr(A_TRIG, 32'h5);
        check("R2 locked chip trigger", {31'd0, chip_rst_o}, 32'd0);
        rd(A_TRIG, d);            check("R2 locked trigger word", d, 32'd0);
        wr(A_CODE, 32'h1111);
        rd(A_CODE, d);            check("R2 locked code write", d, 32'd0);
        unlock_i = 1'b1;
        rd(A_LOCK, d);            check("R2 lock status unlocked", d, 32'd1);
    endtask

    task automatic t_chip_oneshot_r3();
        logic [31:0] d;
        wr(A_PER, 32'h0000_003E);
        wr(A_CODE, 32'h1234);
        clear_cause();
        wr(A_TRIG, 32'h1);
        check("R3 chip reset cycle 1", {30'd0, chip_rst_o, cpu_rst_o}, 32'd3);
        rd(A_TRIG, d);            check("R3 trigger reads 1", d, 32'd1);
        rd(A_CAUSE, d);           check("R3 cause bit0 set", d, 32'h01);
        @(negedge clk);
        check("R3 chip reset cycle 2", {31'd0, chip_rst_o}, 32'd1);
        rd(A_CODE, d);            check("R8 chip pulse wipes code", d, 32'd0);
        @(negedge clk);
        check("R3 chip reset released", {30'd0, chip_rst_o, cpu_rst_o}, 32'd0);
        rd(A_TRIG, d);            check("R3 trigger self-cleared", d, 32'd0);
        rd(A_PER, d);             check("R10 chip pulse clears peripherals", d, 32'd0);
        rd(A_CAUSE, d);           check("R10 cause survives chip pulse", d, 32'h01);
    endtask

    task automatic t_cpu_oneshot_r4();
        logic [31:0] d;
        clear_cause();
        wr(A_TRIG, 32'h2);
        check("R4 cpu pulse cycle 1", {30'd0, chip_rst_o, cpu_rst_o}, 32'd1);
        @(negedge clk);
        check("R4 cpu pulse cycle 2", {30'd0, chip_rst_o, cpu_rst_o}, 32'd1);
        @(negedge clk);
        check("R4 cpu pulse released", {31'd0, cpu_rst_o}, 32'd0);
        rd(A_CAUSE, d);           check("R4 cause bit7", d, 32'h80);
        clear_cause();
        wr(A_TRIG, 32'h3);
        check("R4 both bits take chip path", {31'd0, chip_rst_o}, 32'd1);
        repeat (3) @(negedge clk);
        rd(A_CAUSE, d);           check("R4 both bits cause", d, 32'h01);
    endtask

    task automatic t_dma_r5();
        logic [31:0] d;
        wr(A_TRIG, 32'h4);
        check("R5 dma asserted", {31'd0, dma_rst_o}, 32'd1);
        repeat (5) @(negedge clk);
        check("R5 dma held", {31'd0, dma_rst_o}, 32'd1);
        rd(A_TRIG, d);            check("R5 dma bit reads", d, 32'h4);
        wr(A_TRIG, 32'h0);
        check("R5 dma released, no pulse", {29'd0, dma_rst_o, chip_rst_o, cpu_rst_o}, 32'd0);
    endtask

    task automatic t_periph_r9();
        logic [31:0] d;
        unlock_i = 1'b0;
        wr(A_PER, 32'hFFFF_FFFF);
        rd(A_PER, d);             check("R9 periph word masked", d, PMASK);
        check("R9 periph outputs", periph_rst_o, PMASK);
        wr(A_PER, 32'h0000_0001);
        rd(A_PER, d);             check("R9 reserved bit reads 0", d, 32'd0);
        wr(A_PER, 32'h4000_0100);
        unlock_i = 1'b1;
        wr(A_TRIG, 32'h4);
        @(negedge clk); req_wdt = 1'b1;
        @(negedge clk); req_wdt = 1'b0;
        rd(A_PER, d);             check("R10 watchdog clears peripherals", d, 32'd0);
        check("R10 watchdog clears dma", {31'd0, dma_rst_o}, 32'd0);
    endtask

    task automatic t_por_gate_r7();
        logic [31:0] d;
        wr(A_CODE, 32'h5AA5);
        rd(A_CODE, d);            check("R7 magic code stored", d, 32'h5AA5);
        clear_cause();
        @(negedge clk); req_por = 1'b1; #1;
        check("R7 magic blocks por", {31'd0, chip_rst_o}, 32'd0);
        @(negedge clk); req_por = 1'b0;
        rd(A_CAUSE, d);           check("R7 no cause when blocked", d, 32'd0);
        rd(A_CODE, d);            check("R7 code kept", d, 32'h5AA5);
        wr(A_CODE, 32'h5AA4);
        @(negedge clk); req_por = 1'b1; #1;
        check("R7 other code lets por through", {31'd0, chip_rst_o}, 32'd1);
        @(negedge clk); req_por = 1'b0;
        rd(A_CAUSE, d);           check("R7 por cause bit0", d, 32'h01);
        rd(A_CODE, d);            check("R8 effective por wipes code", d, 32'd0);
    endtask

    task automatic pulse_src(input string name);
        @(negedge clk);
        case (name)
            "pin": req_pin = 1'b1;
            "wdt": req_wdt = 1'b1;
            "bod": req_bod = 1'b1;
            "sys": req_sys = 1'b1;
            default: req_dbg = 1'b1;
        endcase
        #1;
        check("R11 chip reset follows request", {30'd0, chip_rst_o, cpu_rst_o}, 32'd3);
        @(negedge clk);
        {req_pin, req_wdt, req_bod, req_sys, req_dbg} = 5'd0;
    endtask

    task automatic t_sources_r8_r6();
        logic [31:0] d;
        string srcs[5] = '{"pin", "wdt", "bod", "dbg", "sys"};
        logic [31:0] exp_code[5] = '{32'd0, 32'd0, 32'd0, 32'd0, 32'h5AA5};
        clear_cause();
        foreach (srcs[i]) begin
            wr(A_CODE, 32'h5AA5);
            pulse_src(srcs[i]);
            rd(A_CODE, d);
            check({"R8 code after ", srcs[i]}, d, exp_code[i]);
        end
        rd(A_CAUSE, d);           check("R6 source flags", d, 32'h36);
        wr(A_CAUSE, 32'h0);
        rd(A_CAUSE, d);           check("R6 write 0 no effect", d, 32'h36);
        wr(A_CAUSE, 32'h04);
        rd(A_CAUSE, d);           check("R6 write 1 clears one flag", d, 32'h32);
        @(negedge clk); req_bod = 1'b1;
        reg_wr = 1'b1; reg_addr = A_CAUSE; reg_wdata = 32'h10;
        @(negedge clk); reg_wr = 1'b0; req_bod = 1'b0;
        rd(A_CAUSE, d);           check("R6 set wins over clear", d, 32'h32);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state_r1();
        t_lock_r2();
        t_chip_oneshot_r3();
        t_cpu_oneshot_r4();
        t_dma_r5();
        t_periph_r9();
        t_por_gate_r7();
        t_sources_r8_r6();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule